// File: doc/BRIEF.md
# Serial Register and FIFO Access Slave

This block is the serial-bus face of a configuration register bank. An external microcontroller selects the slave and clocks in a command byte. That byte says whether the transfer reads or writes, whether the address steps after each data byte, and which of 64 byte-wide locations to start at. Any number of data bytes may follow. The transfer ends only when the select line goes high again. Two locations are not plain registers: one feeds a transmit FIFO and the other drains a receive FIFO. Bursts on those addresses are issued without address stepping, so that every byte moves one FIFO entry.

All bus pins are brought into the system clock domain by a synchronizer, and the serial clock is edge-detected there. Two options are selectable from the pins. In the first, data in and data out share one bidirectional data line. In the second, an interrupt flag is driven onto the data-in line while the slave is not selected. Toward internal logic the block reports each register write as a one-cycle strobe. It also gives a pop port on the transmit FIFO and a push port on the receive FIFO.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte is the first byte after select goes low. Bit 7 set means write and bit 7 clear means read. Bits 5..0 hold the start address.
- R2: With command bit 6 set, the address advances by one after each data byte. With it clear, every data byte of the burst uses the start address.
- R3: A burst carries any number of data bytes and ends only when select goes high. An advancing address wraps from 0x3F to 0x00.
- R4: Each byte written to address 0x20 is pushed into a 16-entry transmit FIFO, and a byte written while that FIFO is full is dropped. Internal logic sees the oldest entry on txf_data and removes it with txf_pop.
- R5: Each byte read from address 0x21 pops the receive FIFO, and an empty FIFO reads as 0x00. Writes to 0x21 are ignored. Reads of 0x20 return 0x00 and leave the transmit FIFO untouched.
- R6: The bus works in clock mode 0 with the most significant bit first. The slave samples on the rising SCK edge and moves its output after falling edges. The first bit of a read byte is valid before that byte's first rising edge.
- R7: A byte left incomplete when select goes high is thrown away and writes nothing. The next transfer starts cleanly with a command byte.
- R8: In four-wire mode, spi_miso_oe is high exactly while select is low, and the slave never drives the data line while select is low.
- R9: In three-wire mode, read data leaves on spi_dio_o. spi_dio_oe is low during the command byte and high during read data bytes, and spi_miso_oe stays low.
- R10: With the interrupt option on, the slave drives irq_in onto the data line while select is high. It releases the line as soon as select goes low.
- R11: Each completed data byte written to a plain register gives a single-cycle cfg_wr_valid with that address and byte. The value then reads back over the bus.
- R12: Read data for a byte is fetched when the preceding byte completes. A receive-FIFO read burst therefore pops one entry more than the number of bytes the master clocks out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_dio_i | input | 1 | Master data in (shared data line in three-wire mode) |
| spi_dio_o | output | 1 | Value driven onto the data-in line (read data or interrupt) |
| spi_dio_oe | output | 1 | Output enable for the data-in line |
| spi_miso_o | output | 1 | Slave data out in four-wire mode |
| spi_miso_oe | output | 1 | Output enable for the data-out line |
| mode_3wire | input | 1 | Selects the shared bidirectional data line |
| mode_irq_on_dio | input | 1 | Puts irq_in on the data-in line while deselected |
| irq_in | input | 1 | Interrupt flag from internal logic |
| cfg_wr_valid | output | 1 | One-cycle strobe for a register write |
| cfg_wr_addr | output | 6 | Address of the register write |
| cfg_wr_data | output | 8 | Data of the register write |
| txf_pop | input | 1 | Removes the oldest transmit FIFO entry |
| txf_data | output | 8 | Oldest transmit FIFO entry |
| txf_empty | output | 1 | Transmit FIFO holds nothing |
| rxf_push | input | 1 | Pushes rxf_data into the receive FIFO |
| rxf_data | input | 8 | Byte for the receive FIFO |
| rxf_full | output | 1 | Receive FIFO holds 16 entries |

## Verification
The bench runs stepping bursts across the 0x3F boundary. A design without the wrap would write or read a location outside the map, or a stale one. It overfills the transmit FIFO by two bytes, and a design that let those through would show extra or overwritten entries when the FIFO drains. It also reads the receive FIFO past its end, checking both the 0x00 filler and the extra prefetch pop; a design that popped lazily or early would return bytes shifted by one. Further cases cover a transfer aborted after five bits, which must leave the target register and the write strobe untouched, and both pin options, where a wrong enable would drive the line during the command byte or while the master owns it.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
   localparam int ADDR_W    = 6;
   localparam int BYTE_W    = 8;
   localparam int DIR_BIT   = 7;
   localparam int INC_BIT   = 6;
   localparam int REG_COUNT = 1 << ADDR_W;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_e;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[g-1].r;
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_rs_fifo.sv
module spi_rs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             do_push, do_pop;

   assign do_push = push && (level != FULL_LVL);
   assign do_pop  = pop  && (level != '0);

   always_ff @(posedge clk)
      if (do_push) mem[wp] <= din;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         level <= level + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
      end

   assign dout = mem[rp];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
   import spi_rs_pkg::*;
#(
   parameter int    FIFO_DEPTH   = 16,
   parameter int    SYNC_STAGES  = 2,
   parameter addr_t TX_FIFO_ADDR = 6'h20,
   parameter addr_t RX_FIFO_ADDR = 6'h21
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sck,
   input  logic        spi_ss_n,
   input  logic        spi_dio_i,
   output logic        spi_dio_o,
   output logic        spi_dio_oe,
   output logic        spi_miso_o,
   output logic        spi_miso_oe,
   input  logic        mode_3wire,
   input  logic        mode_irq_on_dio,
   input  logic        irq_in,
   output logic        cfg_wr_valid,
   output logic [5:0]  cfg_wr_addr,
   output logic [7:0]  cfg_wr_data,
   input  logic        txf_pop,
   output logic [7:0]  txf_data,
   output logic        txf_empty,
   input  logic        rxf_push,
   input  logic [7:0]  rxf_data,
   output logic        rxf_full
);
   localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

   // pin synchronizer: {sck, ss_n, data}
   logic [2:0] sync_q;
   logic       sck_s, ss_n_s, din_s, sck_d;
   logic       ss_act, sck_rise, sck_fall;

   spi_rs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_ss_n, spi_dio_i}),
      .q     (sync_q)
   );

   assign sck_s  = sync_q[2];
   assign ss_n_s = sync_q[1];
   assign din_s  = sync_q[0];
   assign ss_act = !ss_n_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;

   assign sck_rise = ss_act &&  sck_s && !sck_d;
   assign sck_fall = ss_act && !sck_s &&  sck_d;

   // transaction state
   phase_e     phase;
   logic       phase_data;
   logic       cmd_wr, cmd_inc;
   addr_t      addr, next_addr, fetch_addr;
   logic [2:0] bit_cnt;
   logic [6:0] in_sr;
   byte_t      out_sr, rx_byte, fetch_data;
   logic       byte_done, rd_fetch, wr_do, bank_we;
   logic       tx_push, rx_pop;
   logic [LVL_W-1:0] tx_level, rx_level;
   byte_t      rx_dout;
   byte_t      bank [REG_COUNT];

   assign phase_data = (phase == PH_DATA);
   assign rx_byte    = {in_sr, din_s};
   assign byte_done  = sck_rise && (bit_cnt == 3'd7);
   assign next_addr  = cmd_inc ? addr + 1'b1 : addr;
   assign fetch_addr = phase_data ? next_addr : rx_byte[ADDR_W-1:0];

   assign rd_fetch = byte_done && (phase_data ? !cmd_wr : !rx_byte[DIR_BIT]);
   assign wr_do    = byte_done && phase_data && cmd_wr;
   assign tx_push  = wr_do && (addr == TX_FIFO_ADDR);
   assign bank_we  = wr_do && (addr != TX_FIFO_ADDR) && (addr != RX_FIFO_ADDR);
   assign rx_pop   = rd_fetch && (fetch_addr == RX_FIFO_ADDR);

   always_comb begin
      if (fetch_addr == RX_FIFO_ADDR)      fetch_data = (rx_level == '0) ? '0 : rx_dout;
      else if (fetch_addr == TX_FIFO_ADDR) fetch_data = '0;
      else                                 fetch_data = bank[fetch_addr];
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         phase   <= PH_CMD;
         bit_cnt <= '0;
         in_sr   <= '0;
         cmd_wr  <= 1'b0;
         cmd_inc <= 1'b0;
         addr    <= '0;
         out_sr  <= '0;
      end else if (!ss_act) begin
         phase   <= PH_CMD;
         bit_cnt <= '0;
      end else begin
         if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            in_sr   <= {in_sr[5:0], din_s};
         end
         if (byte_done) begin
            if (!phase_data) begin
               phase   <= PH_DATA;
               cmd_wr  <= rx_byte[DIR_BIT];
               cmd_inc <= rx_byte[INC_BIT];
               addr    <= rx_byte[ADDR_W-1:0];
            end else begin
               addr    <= next_addr;
            end
         end
         if (rd_fetch)
            out_sr <= fetch_data;
         else if (sck_fall && (bit_cnt != 3'd0))
            out_sr <= {out_sr[6:0], 1'b0};
      end

   // plain register bank
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) bank[i] <= '0;
      end else if (bank_we) begin
         bank[addr] <= rx_byte;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cfg_wr_valid <= 1'b0;
         cfg_wr_addr  <= '0;
         cfg_wr_data  <= '0;
      end else begin
         cfg_wr_valid <= bank_we;
         if (bank_we) begin
            cfg_wr_addr <= addr;
            cfg_wr_data <= rx_byte;
         end
      end

   // register-file FIFOs
   spi_rs_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk (clk), .rst_n (rst_n),
      .push (tx_push), .din (rx_byte),
      .pop (txf_pop), .dout (txf_data), .level (tx_level)
   );

   spi_rs_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk (clk), .rst_n (rst_n),
      .push (rxf_push), .din (rxf_data),
      .pop (rx_pop), .dout (rx_dout), .level (rx_level)
   );

   assign txf_empty = (tx_level == '0);
   assign rxf_full  = (rx_level == FULL_LVL);

   // pin muxing; enables follow the raw select so the line is freed at once
   assign spi_miso_o  = out_sr[7];
   assign spi_miso_oe = !mode_3wire && !spi_ss_n;
   assign spi_dio_o   = spi_ss_n ? irq_in : out_sr[7];
   assign spi_dio_oe  = spi_ss_n ? mode_irq_on_dio
                                 : (mode_3wire && phase_data && !cmd_wr);
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
   parameter int DEPTH   = 16,
   parameter int SYNC_N  = 2,
   parameter int TX_A    = 32,
   parameter int RX_A    = 33
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_wr_valid,
   input logic                     ss_act,
   input logic                     phase_data,
   input logic                     cmd_inc,
   input logic [5:0]               addr,
   input logic [$clog2(DEPTH):0]   tx_level,
   input logic                     txf_pop,
   input logic [$clog2(DEPTH):0]   rx_level,
   input logic                     rxf_push
);
   initial begin : p_params
      AST_DEPTH_POW2 : assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("FIFO depth must be a power of two of at least 2"); // R4
      AST_SYNC_DEPTH : assert (SYNC_N >= 2)
         else $error("synchronizer needs at least two stages"); // R6
      AST_FIFO_ADDRS : assert (TX_A != RX_A && TX_A < 64 && RX_A < 64)
         else $error("FIFO addresses must differ and lie in the map"); // R5
   end

   AST_WR_SINGLE_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_valid |=> !cfg_wr_valid); // R11

   AST_WR_ONLY_SELECTED : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_valid |-> $past(ss_act)); // R7

   AST_NO_OVERFLOW : assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= ($clog2(DEPTH)+1)'(DEPTH)); // R4

   AST_FULL_DROPS : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == ($clog2(DEPTH)+1)'(DEPTH) && !txf_pop) |=>
         (tx_level == ($clog2(DEPTH)+1)'(DEPTH))); // R4

   AST_EMPTY_READ_NO_POP : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0 && !rxf_push) |=> (rx_level == '0)); // R5

   AST_ADDR_HOLD_NOINC : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_data) && phase_data && !cmd_inc) |-> $stable(addr)); // R2
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
   .DEPTH  (FIFO_DEPTH),
   .SYNC_N (SYNC_STAGES),
   .TX_A   (int'(TX_FIFO_ADDR)),
   .RX_A   (int'(RX_FIFO_ADDR))
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_valid (cfg_wr_valid),
   .ss_act       (ss_act),
   .phase_data   (phase_data),
   .cmd_inc      (cmd_inc),
   .addr         (addr),
   .tx_level     (tx_level),
   .txf_pop      (txf_pop),
   .rx_level     (rx_level),
   .rxf_push     (rxf_push)
);

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
   localparam int HALF = 8;
   localparam int DEPTH = 16;
   localparam logic [5:0] TXA = 6'h20;
   localparam logic [5:0] RXA = 6'h21;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, spi_sck, spi_ss_n, spi_dio_i;
   logic       spi_dio_o, spi_dio_oe, spi_miso_o, spi_miso_oe;
   logic       mode_3wire, mode_irq_on_dio, irq_in;
   logic       cfg_wr_valid;
   logic [5:0] cfg_wr_addr;
   logic [7:0] cfg_wr_data, txf_data, rxf_data;
   logic       txf_pop, txf_empty, rxf_push, rxf_full;

   spi_reg_slave dut_i (
      .clk (clk), .rst_n (rst_n),
      .spi_sck (spi_sck), .spi_ss_n (spi_ss_n), .spi_dio_i (spi_dio_i),
      .spi_dio_o (spi_dio_o), .spi_dio_oe (spi_dio_oe),
      .spi_miso_o (spi_miso_o), .spi_miso_oe (spi_miso_oe),
      .mode_3wire (mode_3wire), .mode_irq_on_dio (mode_irq_on_dio), .irq_in (irq_in),
      .cfg_wr_valid (cfg_wr_valid), .cfg_wr_addr (cfg_wr_addr), .cfg_wr_data (cfg_wr_data),
      .txf_pop (txf_pop), .txf_data (txf_data), .txf_empty (txf_empty),
      .rxf_push (rxf_push), .rxf_data (rxf_data), .rxf_full (rxf_full)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference model
   logic [7:0] mbank [64];
   logic [7:0] mtx[$];
   logic [7:0] mrx[$];
   logic [7:0] wq[$];
   logic [7:0] rq[$];
   logic [7:0] eq[$];
   int         exp_wr = 0;
   int         seen_wr = 0;
   logic [5:0] seen_addr;
   logic [7:0] seen_data;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m_fetch(input logic [5:0] a);
      if (a == RXA) return (mrx.size() > 0) ? mrx.pop_front() : 8'h00;
      if (a == TXA) return 8'h00;
      return mbank[a];
   endfunction

   function automatic void m_write(input logic [5:0] a, input logic [7:0] d);
      if (a == TXA) begin
         if (mtx.size() < DEPTH) mtx.push_back(d);
      end else if (a != RXA) begin
         mbank[a] = d;
         exp_wr++;
      end
   endfunction

   task automatic wait_half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xbyte(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any);
      oe_all = 1'b1; oe_any = 1'b0; rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         spi_dio_i = tx[i];
         wait_half();
         rx[i]  = mode_3wire ? spi_dio_o : spi_miso_o;
         oe_all = oe_all & spi_dio_oe;
         oe_any = oe_any | spi_dio_oe;
         spi_sck = 1'b1;
         wait_half();
         spi_sck = 1'b0;
      end
   endtask

   task automatic xfer(input bit wr, input bit inc, input logic [5:0] a, input int n);
      logic [7:0] r;
      bit oa, oo;
      logic [5:0] ca;
      rq.delete(); eq.delete();
      spi_ss_n = 1'b0;
      wait_half();
      xbyte({wr, inc, a}, 8, r, oa, oo);
      if (mode_3wire) chk(!oo, "R9 dio released in command byte", 32'(oo), 0);
      else            chk(!oo, "R8 dio released while selected", 32'(oo), 0);
      ca = a;
      if (!wr) eq.push_back(m_fetch(ca));
      for (int k = 0; k < n; k++) begin
         xbyte(wr ? wq[k] : 8'h00, 8, r, oa, oo);
         if (wr) m_write(ca, wq[k]);
         else begin
            rq.push_back(r);
            if (mode_3wire) chk(oa, "R9 dio driven in read data", 32'(oa), 1);
         end
         if (inc) ca = ca + 1'b1;
         if (!wr) eq.push_back(m_fetch(ca));
      end
      wait_half();
      spi_ss_n = 1'b1;
      wait_half(); wait_half();
   endtask

   task automatic cmp_reads(input string req, input int n);
      for (int k = 0; k < n; k++)
         chk(rq[k] === eq[k], req, 32'(rq[k]), 32'(eq[k]));
   endtask

   task automatic push_rx(input logic [7:0] d);
      rxf_data = d; rxf_push = 1'b1;
      @(negedge clk);
      rxf_push = 1'b0;
      mrx.push_back(d);
   endtask

   task automatic pop_tx(input string req);
      logic [7:0] e;
      e = mtx.pop_front();
      chk(txf_data === e, req, 32'(txf_data), 32'(e));
      txf_pop = 1'b1;
      @(negedge clk);
      txf_pop = 1'b0;
   endtask

   // write strobe monitor
   always @(negedge clk) begin
      if (cfg_wr_valid) begin
         seen_wr++;
         seen_addr = cfg_wr_addr;
         seen_data = cfg_wr_data;
      end
   end

   // per-clock pin-enable comparison against the reference rules
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (spi_ss_n) begin
            chk(!spi_miso_oe, "R8 miso released when deselected", 32'(spi_miso_oe), 0);
            chk(spi_dio_oe == mode_irq_on_dio, "R10 dio enable when deselected",
                32'(spi_dio_oe), 32'(mode_irq_on_dio));
            if (mode_irq_on_dio)
               chk(spi_dio_o == irq_in, "R10 irq value on dio", 32'(spi_dio_o), 32'(irq_in));
         end else if (mode_3wire) begin
            chk(!spi_miso_oe, "R9 miso idle in three-wire", 32'(spi_miso_oe), 0);
         end else begin
            chk(spi_miso_oe, "R8 miso driven while selected", 32'(spi_miso_oe), 1);
            chk(!spi_dio_oe, "R8 dio not driven while selected", 32'(spi_dio_oe), 0);
         end
      end
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         done = 1'b1;
         report();
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] r;
      bit oa, oo;
      int wr_before;
      for (int i = 0; i < 64; i++) mbank[i] = 8'h00;
      rst_n = 1'b0; spi_sck = 1'b0; spi_ss_n = 1'b1; spi_dio_i = 1'b0;
      mode_3wire = 1'b0; mode_irq_on_dio = 1'b0; irq_in = 1'b0;
      txf_pop = 1'b0; rxf_push = 1'b0; rxf_data = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state
      chk(!cfg_wr_valid, "R11 reset strobe low", 32'(cfg_wr_valid), 0);
      chk(txf_empty, "R4 reset tx empty", 32'(txf_empty), 1);
      chk(!rxf_full, "R5 reset rx not full", 32'(rxf_full), 0);
      chk(!spi_miso_oe && !spi_dio_oe, "R8 reset pins released",
          32'({spi_miso_oe, spi_dio_oe}), 0);

      // R1 R11: single write, strobe and read back
      wq = '{8'hA5};
      xfer(1'b1, 1'b0, 6'h05, 1);
      chk(seen_wr == exp_wr, "R11 strobe count", 32'(seen_wr), 32'(exp_wr));
      chk(seen_addr == 6'h05 && seen_data == 8'hA5, "R11 strobe address/data",
          32'({seen_addr, seen_data}), 32'({6'h05, 8'hA5}));
      xfer(1'b0, 1'b0, 6'h05, 1);
      cmp_reads("R1 R6 single read", 1);

      // R3 R2: stepping burst across the top of the map
      wq = '{8'h81, 8'h3C, 8'hE7, 8'h18};
      xfer(1'b1, 1'b1, 6'h3E, 4);
      chk(mbank[6'h00] == 8'hE7, "R3 wrapped write model", 32'(mbank[0]), 32'hE7);
      xfer(1'b0, 1'b1, 6'h3E, 4);
      cmp_reads("R3 wrapping read burst", 4);
      chk(seen_wr == exp_wr, "R11 burst strobe count", 32'(seen_wr), 32'(exp_wr));

      // R2: fixed-address burst keeps last byte
      wq = '{8'h11, 8'h22, 8'h5A};
      xfer(1'b1, 1'b0, 6'h10, 3);
      xfer(1'b0, 1'b0, 6'h10, 3);
      cmp_reads("R2 fixed-address burst", 3);
      xfer(1'b0, 1'b0, 6'h11, 1);
      cmp_reads("R2 neighbour untouched", 1);

      // R4: overfill the transmit FIFO
      wq.delete();
      for (int i = 0; i < DEPTH + 2; i++) wq.push_back(8'(8'h40 + i));
      xfer(1'b1, 1'b0, TXA, DEPTH + 2);
      chk(!txf_empty, "R4 tx holds data", 32'(txf_empty), 0);
      for (int i = 0; i < DEPTH; i++) pop_tx("R4 tx FIFO order and drop");
      chk(txf_empty, "R4 tx empty after drain", 32'(txf_empty), 1);

      // R5 R12: receive FIFO read past empty
      push_rx(8'hC3); push_rx(8'h96); push_rx(8'h0F);
      xfer(1'b0, 1'b0, RXA, 4);
      cmp_reads("R5 rx reads then 0x00", 4);
      push_rx(8'h71); push_rx(8'h72);
      xfer(1'b0, 1'b0, RXA, 1);
      cmp_reads("R12 first rx byte", 1);
      xfer(1'b0, 1'b0, RXA, 1);
      cmp_reads("R12 prefetch consumed second byte", 1);

      // R5: write to rx address ignored, read of tx address gives zero
      push_rx(8'hB4);
      wr_before = seen_wr;
      wq = '{8'h77};
      xfer(1'b1, 1'b0, RXA, 1);
      chk(seen_wr == wr_before, "R5 rx write no strobe", 32'(seen_wr), 32'(wr_before));
      xfer(1'b0, 1'b0, RXA, 1);
      cmp_reads("R5 rx write ignored", 1);
      wq = '{8'hD2};
      xfer(1'b1, 1'b0, TXA, 1);
      xfer(1'b0, 1'b0, TXA, 2);
      cmp_reads("R5 tx address reads zero", 2);
      chk(!txf_empty, "R5 tx not popped by read", 32'(txf_empty), 0);
      pop_tx("R5 tx content intact");

      // R7: aborted byte
      wq = '{8'h5A};
      xfer(1'b1, 1'b0, 6'h07, 1);
      wr_before = seen_wr;
      spi_ss_n = 1'b0;
      wait_half();
      xbyte({1'b1, 1'b0, 6'h07}, 8, r, oa, oo);
      xbyte(8'h3C, 5, r, oa, oo);
      wait_half();
      spi_ss_n = 1'b1;
      wait_half(); wait_half();
      chk(seen_wr == wr_before, "R7 no strobe for partial byte", 32'(seen_wr), 32'(wr_before));
      xfer(1'b0, 1'b0, 6'h07, 1);
      cmp_reads("R7 register unchanged after abort", 1);

      // R9: three-wire mode
      mode_3wire = 1'b1;
      @(negedge clk);
      wq = '{8'h9C, 8'h63};
      xfer(1'b1, 1'b1, 6'h2A, 2);
      xfer(1'b0, 1'b1, 6'h2A, 2);
      cmp_reads("R9 three-wire read", 2);
      mode_3wire = 1'b0;
      @(negedge clk);

      // R10: interrupt on data line
      mode_irq_on_dio = 1'b1;
      irq_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(spi_dio_oe && spi_dio_o, "R10 irq high shown", 32'({spi_dio_oe, spi_dio_o}), 3);
      irq_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(spi_dio_oe && !spi_dio_o, "R10 irq low shown", 32'({spi_dio_oe, spi_dio_o}), 2);
      irq_in = 1'b1;
      xfer(1'b0, 1'b0, 6'h05, 1);
      cmp_reads("R10 read with irq option on", 1);
      mode_irq_on_dio = 1'b0;
      irq_in = 1'b0;
      repeat (4) @(negedge clk);

      chk(seen_wr == exp_wr, "R11 final strobe count", 32'(seen_wr), 32'(exp_wr));
      done = 1'b1;
      report();
      $finish;
   end
endmodule